// File: doc/BRIEF.md
# Ground-Differential Restraint Combiner

This block forms the operating and restraining quantities for a restricted ground-fault differential element. On each input sample it receives the ground CT current, the neutral current built from the three phase CTs, and the zero-, negative- and positive-sequence magnitudes of the phase currents. It produces a differential (operating) signal and a raw restraint signal. Phasor estimation, sequence extraction and the energization tracker that drives the multiplier select are outside this block.

Values are unsigned Q8.8 per-unit of the phase CT. The ground and neutral currents are treated as collinear phasors. Each arrives as a magnitude, and the ground input also carries a polarity flag that says whether it opposes the neutral current. The ground magnitude is first rescaled to the phase CT base by a Q8.8 ratio parameter. The differential signal is the magnitude of the vector sum of ground and neutral. The restraint is the largest of three parts:

- a zero-sequence part, which is the magnitude of ground minus neutral;
- a negative-sequence part, which is I2 or 3×I2 depending on the multiplier select;
- a piecewise positive-sequence part.

A sample is accepted on a valid strobe. The results appear on registered outputs one clock later and hold until the next accepted sample.

Top module: `gnd_diff_restraint`

## Requirements
- R1: The differential output equals sat(G + N) when the opposite-polarity flag is 0, and |G − N| when it is 1. G is the rescaled ground magnitude, N is the neutral magnitude, and sat() clamps at 0xFFFF.
- R2: The rescaled ground magnitude is G = floor(ground × GND_RATIO / 256), clamped to 0xFFFF. GND_RATIO is Q8.8 and defaults to 512 (×2.0).
- R3: The zero-sequence restraint equals |G − N| when the flag is 0, and sat(G + N) when it is 1.
- R4: The negative-sequence restraint equals I2 when the multiplier select is 0. When the select is 1 it equals 3×I2, saturated at 0xFFFF.
- R5: When I1 ≤ 0x0180 (1.5 pu), the positive-sequence restraint is I1 shifted right by three bits, truncated.
- R6: When I1 > 0x0180, the positive-sequence restraint is 3×(I1 − I0) saturated at 0xFFFF if I1 > I0, and 0 otherwise.
- R7: The restraint output equals the maximum of the three restraint parts.
- R8: The output-valid signal is high exactly one clock after the input valid is high, and low one clock after it is low.
- R9: The data outputs load only on a valid sample. While the input valid is low they hold their previous values whatever the data inputs do.
- R10: After reset both data outputs are 0 and the output-valid signal is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Sample strobe |
| gndMag | input | 16 | Ground CT magnitude, Q8.8, ground CT base |
| gndOpp | input | 1 | 1 when ground current opposes neutral current |
| neuMag | input | 16 | Phase-derived neutral magnitude, Q8.8 |
| seqZero | input | 16 | Zero-sequence magnitude I0, Q8.8 |
| seqNeg | input | 16 | Negative-sequence magnitude I2, Q8.8 |
| seqPos | input | 16 | Positive-sequence magnitude I1, Q8.8 |
| mulSel | input | 1 | Negative-sequence multiplier select (0: ×1, 1: ×3) |
| outValid | output | 1 | Result strobe, one clock after inValid |
| diffOut | output | 16 | Differential signal, Q8.8 |
| restOut | output | 16 | Raw restraint signal, Q8.8 |

## Verification
The first pattern is an external ground fault, where ground opposes neutral. It should give a small differential with a large zero-sequence restraint. The second is an internal fault with the two in phase, which should give the reverse. Together they show whether the polarity handling has been swapped between the operating and restraining paths. A large ground input checks the rescale clamp. A large I2 with the select toggled shows whether the ×3 path is taken and whether it saturates. I1 values are set just at and just above 1.5 pu, with I0 both below and above I1, to check each branch of the positive-sequence law and the threshold comparison. A burst of changed inputs with the strobe low confirms that the outputs hold.

// File: rtl/gdr_pkg.sv
package gdr_pkg;
  localparam int MAG_W  = 16;
  localparam int FRAC_W = 8;

  typedef logic [MAG_W-1:0] mag_t;

  typedef struct packed {
    logic load;
  } gdr_strobe_t;

  function automatic mag_t satAdd(mag_t a, mag_t b);
    logic [MAG_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[MAG_W] ? '1 : s[MAG_W-1:0];
  endfunction

  function automatic mag_t absDiff(mag_t a, mag_t b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  function automatic mag_t satTimes3(mag_t a);
    logic [MAG_W+1:0] t;
    t = {2'b00, a} + {1'b0, a, 1'b0};
    return (|t[MAG_W+1:MAG_W]) ? '1 : t[MAG_W-1:0];
  endfunction

  function automatic mag_t max3(mag_t a, mag_t b, mag_t c);
    mag_t m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/gdr_ctrl.sv
module gdr_ctrl
  import gdr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output gdr_strobe_t strobe,
  output logic        outValid
);
  always_comb begin
    strobe      = '0;
    strobe.load = inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/gdr_datapath.sv
module gdr_datapath
  import gdr_pkg::*;
#(
  parameter int GND_RATIO  = 512,
  parameter int FAULT_LVL  = 384,
  parameter int LOAD_SHIFT = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  gdr_strobe_t strobe,
  input  mag_t        gndMag,
  input  logic        gndOpp,
  input  mag_t        neuMag,
  input  mag_t        seqZero,
  input  mag_t        seqNeg,
  input  mag_t        seqPos,
  input  logic        mulSel,
  output mag_t        diffOut,
  output mag_t        restOut
);
  localparam int   PROD_W  = 2 * MAG_W;
  localparam mag_t RATIO_C = MAG_W'(GND_RATIO);
  localparam mag_t FAULT_C = MAG_W'(FAULT_LVL);

  // Ground rescale to phase CT base
  logic [PROD_W-1:0] gndProd;
  logic [PROD_W-1:0] gndShift;
  mag_t              gndScaled;

  always_comb begin
    gndProd   = {{MAG_W{1'b0}}, gndMag} * {{MAG_W{1'b0}}, RATIO_C};
    gndShift  = gndProd >> FRAC_W;
    gndScaled = (|gndShift[PROD_W-1:MAG_W]) ? '1 : gndShift[MAG_W-1:0];
  end

  // Vector sum / difference of collinear phasors
  mag_t sumMag, difMag, diffNext, ir0Next;
  always_comb begin
    sumMag   = satAdd(gndScaled, neuMag);
    difMag   = absDiff(gndScaled, neuMag);
    diffNext = gndOpp ? difMag : sumMag;
    ir0Next  = gndOpp ? sumMag : difMag;
  end

  // Negative-sequence part
  mag_t ir2Next;
  always_comb ir2Next = mulSel ? satTimes3(seqNeg) : seqNeg;

  // Positive-sequence part
  mag_t ir1Next;
  logic faultLvl;
  always_comb begin
    faultLvl = seqPos > FAULT_C;
    if (!faultLvl)            ir1Next = seqPos >> LOAD_SHIFT;
    else if (seqPos > seqZero) ir1Next = satTimes3(seqPos - seqZero);
    else                      ir1Next = '0;
  end

  mag_t restNext;
  always_comb restNext = max3(ir0Next, ir1Next, ir2Next);

  mag_t ir0Q, ir1Q, ir2Q;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      diffOut <= '0;
      restOut <= '0;
      ir0Q    <= '0;
      ir1Q    <= '0;
      ir2Q    <= '0;
    end else if (strobe.load) begin
      diffOut <= diffNext;
      restOut <= restNext;
      ir0Q    <= ir0Next;
      ir1Q    <= ir1Next;
      ir2Q    <= ir2Next;
    end
  end

  // R7
  rest_dominates_chk: assert property (@(posedge clk) disable iff (!rstN)
    (restOut >= ir0Q) && (restOut >= ir1Q) && (restOut >= ir2Q));
  // R7
  rest_is_member_chk: assert property (@(posedge clk) disable iff (!rstN)
    (restOut == ir0Q) || (restOut == ir1Q) || (restOut == ir2Q));
  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(diffOut) && $stable(restOut));
  // R4
  neg_unity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !mulSel) |=> ir2Q == $past(seqNeg));
  // R5
  load_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && seqPos <= FAULT_C) |=> ir1Q <= $past(seqPos));
  // R6
  pos_removed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && seqPos > FAULT_C && seqPos <= seqZero) |=> ir1Q == '0);
  // R1
  inphase_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !gndOpp) |=> diffOut >= $past(neuMag));
endmodule

// File: rtl/gnd_diff_restraint.sv
module gnd_diff_restraint
  import gdr_pkg::*;
#(
  parameter int GND_RATIO  = 512,
  parameter int FAULT_LVL  = 384,
  parameter int LOAD_SHIFT = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [15:0] gndMag,
  input  logic        gndOpp,
  input  logic [15:0] neuMag,
  input  logic [15:0] seqZero,
  input  logic [15:0] seqNeg,
  input  logic [15:0] seqPos,
  input  logic        mulSel,
  output logic        outValid,
  output logic [15:0] diffOut,
  output logic [15:0] restOut
);
  gdr_strobe_t strobe;

  gdr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  gdr_datapath #(
    .GND_RATIO  (GND_RATIO),
    .FAULT_LVL  (FAULT_LVL),
    .LOAD_SHIFT (LOAD_SHIFT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .gndMag  (gndMag),
    .gndOpp  (gndOpp),
    .neuMag  (neuMag),
    .seqZero (seqZero),
    .seqNeg  (seqNeg),
    .seqPos  (seqPos),
    .mulSel  (mulSel),
    .diffOut (diffOut),
    .restOut (restOut)
  );
endmodule

// File: tb/gnd_diff_restraint_tb.sv
module gnd_diff_restraint_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] gndMag = '0, neuMag = '0, seqZero = '0, seqNeg = '0, seqPos = '0;
  logic        gndOpp = 1'b0, mulSel = 1'b0;
  logic        outValid;
  logic [15:0] diffOut, restOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gnd_diff_restraint u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .gndMag(gndMag), .gndOpp(gndOpp), .neuMag(neuMag),
    .seqZero(seqZero), .seqNeg(seqNeg), .seqPos(seqPos), .mulSel(mulSel),
    .outValid(outValid), .diffOut(diffOut), .restOut(restOut)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampW(int v);
    return (v > 65535) ? 65535 : v;
  endfunction

  function automatic int scaleG(int g);        // R2
    return clampW((g * 512) / 256);
  endfunction

  function automatic int expDiff(int g, bit opp, int n);   // R1
    int gs = scaleG(g);
    if (opp) return (gs > n) ? gs - n : n - gs;
    return clampW(gs + n);
  endfunction

  function automatic int expIr0(int g, bit opp, int n);    // R3
    int gs = scaleG(g);
    if (!opp) return (gs > n) ? gs - n : n - gs;
    return clampW(gs + n);
  endfunction

  function automatic int expIr1(int i1, int i0);           // R5 R6
    if (i1 <= 384) return i1 / 8;
    if (i1 > i0) return clampW(3 * (i1 - i0));
    return 0;
  endfunction

  function automatic int expRest(int g, bit opp, int n, int i0, int i1, int i2, bit ms);
    int a = expIr0(g, opp, n);
    int b = expIr1(i1, i0);
    int c = ms ? clampW(3 * i2) : i2;                      // R4
    int m = (a > b) ? a : b;                               // R7
    return (m > c) ? m : c;
  endfunction

  // Drive one valid sample at a negedge, sample results at the next negedge.
  task automatic sample(string req, int g, bit opp, int n, int i0, int i1, int i2, bit ms);
    @(negedge clk);
    gndMag = 16'(g); gndOpp = opp; neuMag = 16'(n);
    seqZero = 16'(i0); seqPos = 16'(i1); seqNeg = 16'(i2); mulSel = ms;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({req, " outValid"}, int'(outValid), 1);
    check({req, " diff"}, int'(diffOut), expDiff(g, opp, n));
    check({req, " rest"}, int'(restOut), expRest(g, opp, n, i0, i1, i2, ms));
  endtask

  task automatic testReset();
    check("R10 outValid", int'(outValid), 0);
    check("R10 diff", int'(diffOut), 0);
    check("R10 rest", int'(restOut), 0);
  endtask

  task automatic testExternalFault();   // ground opposes neutral
    sample("R1 R3 external", 16'h0180, 1'b1, 16'h0300, 0, 0, 0, 1'b0);
    check("R3 external rest", int'(restOut), 16'h0600);
    check("R1 external diff", int'(diffOut), 0);
  endtask

  task automatic testInternalFault();   // in phase
    sample("R1 R3 internal", 16'h0100, 1'b0, 16'h0080, 0, 0, 0, 1'b0);
    check("R1 internal diff", int'(diffOut), 16'h0280);
  endtask

  task automatic testRescaleClamp();
    sample("R2 clamp", 16'hF000, 1'b0, 16'h0010, 0, 0, 0, 1'b0);
    check("R2 clamp diff", int'(diffOut), 65535);
    sample("R2 scale", 16'h0040, 1'b1, 16'h0000, 0, 0, 0, 1'b0);
    check("R2 scale diff", int'(diffOut), 16'h0080);
  endtask

  task automatic testNegSeq();
    sample("R4 unity", 0, 1'b0, 0, 0, 0, 16'h0200, 1'b0);
    check("R4 unity rest", int'(restOut), 16'h0200);
    sample("R4 triple", 0, 1'b0, 0, 0, 0, 16'h0200, 1'b1);
    check("R4 triple rest", int'(restOut), 16'h0600);
    sample("R4 saturate", 0, 1'b0, 0, 0, 0, 16'h6000, 1'b1);
    check("R4 saturate rest", int'(restOut), 65535);
  endtask

  task automatic testPosSeq();
    sample("R5 at threshold", 0, 1'b0, 0, 0, 384, 0, 1'b0);
    check("R5 threshold rest", int'(restOut), 48);
    sample("R5 truncate", 0, 1'b0, 0, 0, 23, 0, 1'b0);
    check("R5 truncate rest", int'(restOut), 2);
    sample("R6 just above", 0, 1'b0, 0, 0, 385, 0, 1'b0);
    check("R6 above rest", int'(restOut), 1155);
    sample("R6 excess", 0, 1'b0, 0, 16'h0100, 16'h0400, 0, 1'b0);
    check("R6 excess rest", int'(restOut), 16'h0900);
    sample("R6 removed", 0, 1'b0, 0, 16'h0500, 16'h0400, 0, 1'b0);
    check("R6 removed rest", int'(restOut), 0);
    sample("R6 saturate", 0, 1'b0, 0, 0, 16'hF000, 0, 1'b0);
    check("R6 saturate rest", int'(restOut), 65535);
  endtask

  task automatic testMaxSelect();
    sample("R7 mixed", 16'h0100, 1'b0, 16'h0050, 16'h0100, 16'h0400, 16'h0300, 1'b1);
    check("R7 picks ir2", int'(restOut), 16'h0900);
  endtask

  task automatic testHold();
    int d0, r0;
    sample("R9 prime", 16'h0100, 1'b0, 16'h0100, 0, 16'h0100, 16'h0010, 1'b0);
    d0 = int'(diffOut); r0 = int'(restOut);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      gndMag = 16'(16'h0700 + k); neuMag = 16'h0033; seqNeg = 16'h2000;
      mulSel = 1'b1; seqPos = 16'h0900; gndOpp = 1'(k);
      inValid = 1'b0;
    end
    @(negedge clk);
    check("R9 hold diff", int'(diffOut), d0);
    check("R9 hold rest", int'(restOut), r0);
    check("R8 idle outValid", int'(outValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    check("R8 no strobe", int'(outValid), 0);
    testExternalFault();
    testInternalFault();
    testRescaleClamp();
    testNegSeq();
    testPosSeq();
    testMaxSelect();
    testHold();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule